// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block owns the floating-point status word of a processor and keeps it in step with the exception flags that the arithmetic units report. When an operation begins, a start strobe clears the stale trap-type and current-exception fields. When the operation completes, a valid strobe presents five IEEE flags: invalid, overflow, underflow, divide-by-zero and inexact. The unit writes these flags into the current-exception field and compares that field with the trap-enable field of the same word.

If any enabled exception is present, the unit writes the IEEE-exception code into the trap-type field and pulses a trap request. The accrued field is left unchanged in that case. If no enabled exception is present, the current flags are ORed into the accrued field. Software can load the whole word at any time, and that write takes priority over hardware updates. The arithmetic itself is outside this block.

Top module: `fpx_status_unit`

## Requirements
- R1: While reset is high and in the cycle after it, the status word `fsr_q` reads 0 and `trap_req` reads 0.
- R2: A cycle with `op_start` high clears the trap-type field (bits 16:14) and the current-exception field (bits 4:0). Every other bit keeps its value when no flags are applied in that cycle.
- R3: When `flag_vld` is high, flag input bit 4 (invalid), bit 3 (overflow), bit 2 (underflow), bit 1 (divide-by-zero) and bit 0 (inexact) are ORed into the same bit positions of the current-exception field. When `op_start` is high in the same cycle, the clear happens first.
- R4: A flag update for which the new current-exception field ANDed with the trap-enable field (bits 27:23, read as a 5-bit value) is nonzero writes code 1 into bits 16:14 and leaves the accrued field (bits 9:5) unchanged.
- R5: `trap_req` rises in the same cycle that the status word shows a trapping update. It is high for that one cycle only, unless another trapping update follows immediately.
- R6: A flag update with no enabled exception ORs the new current-exception field into the accrued field (current bit i goes to bit 5+i) and leaves the trap-type field unchanged.
- R7: A `flag_vld` cycle whose five flags are all zero changes no bit beyond the clear of R2, and does not raise `trap_req`.
- R8: A cycle with `sw_we` high loads `sw_wdata` into the whole status word and raises no trap, regardless of `op_start` and `flag_vld` in the same cycle.
- R9: Bits outside the current, accrued and trap-type fields change only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start of a floating-point operation |
| flag_vld | input | 1 | Exception flags below are valid this cycle |
| flag_in | input | 5 | Flags: invalid, overflow, underflow, divide-by-zero, inexact (bit 4 down to bit 0) |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 32 | Software write data |
| fsr_q | output | 32 | Registered status word |
| trap_req | output | 1 | Registered trap request pulse |

## Verification
The main sweep runs every combination of the 32 trap-enable masks and the 32 flag sets. Each run starts from a preloaded word with stale trap-type, current-exception and unrelated bits set. This separates the three outcomes from one another: trap with the accrued field held, merge into the accrued field, and no change when no flags are raised. Separate patterns split the start strobe from the flag strobe, to show the clear on its own and the ORing of flags into an uncleared field. Further patterns collide a software write with a trapping update, check that the trap pulse drops on the following idle cycle, and check the reset state.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAGS = 5;
  // flag positions inside the 5-bit flag vector and current field
  localparam int FLG_INVALID = 4;
  localparam int FLG_OVERFLOW = 3;
  localparam int FLG_UNDERFLOW = 2;
  localparam int FLG_DIVZERO = 1;
  localparam int FLG_INEXACT = 0;
  typedef logic [NFLAGS-1:0] fpx_flags_t;
endpackage

// File: rtl/fpx_flag_gather.sv
module fpx_flag_gather
  import fpx_pkg::*;
(
  input  logic       vld_i,
  input  fpx_flags_t flags_i,
  output fpx_flags_t cexc_o,
  output logic       any_o
);
  localparam int IDX [NFLAGS] = '{FLG_INEXACT, FLG_DIVZERO, FLG_UNDERFLOW,
                                   FLG_OVERFLOW, FLG_INVALID};
  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    assign cexc_o[IDX[g]] = vld_i & flags_i[IDX[g]];
  end
  assign any_o = |cexc_o;
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
(
  input  fpx_flags_t cexc_i,
  input  fpx_flags_t tem_i,
  output logic       trap_o
);
  fpx_flags_t hit;
  for (genvar g = 0; g < NFLAGS; g++) begin : g_hit
    assign hit[g] = cexc_i[g] & tem_i[g];
  end
  assign trap_o = |hit;
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int FSR_W     = 32,
  parameter int CEXC_LSB  = 0,
  parameter int AEXC_LSB  = 5,
  parameter int TEM_LSB   = 23,
  parameter int FTT_LSB   = 14,
  parameter int FTT_W     = 3,
  parameter int IEEE_CODE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start,
  input  logic             flag_vld,
  input  logic [4:0]       flag_in,
  input  logic             sw_we,
  input  logic [FSR_W-1:0] sw_wdata,
  output logic [FSR_W-1:0] fsr_q,
  output logic             trap_req
);
  localparam logic [FTT_W-1:0] FTT_IEEE = FTT_W'(IEEE_CODE);

  logic [FSR_W-1:0] base_w, next_w;
  fpx_flags_t       raised, cexc_new;
  logic             any_raised, enabled_hit, trap_nxt;

  fpx_flag_gather u_gather (
    .vld_i  (flag_vld),
    .flags_i(flag_in),
    .cexc_o (raised),
    .any_o  (any_raised)
  );

  // start-of-operation clear is applied before the flags are merged
  always_comb begin
    base_w = fsr_q;
    if (op_start) begin
      base_w[FTT_LSB +: FTT_W]   = '0;
      base_w[CEXC_LSB +: NFLAGS] = '0;
    end
  end

  assign cexc_new = base_w[CEXC_LSB +: NFLAGS] | raised;

  fpx_trap_eval u_eval (
    .cexc_i(cexc_new),
    .tem_i (base_w[TEM_LSB +: NFLAGS]),
    .trap_o(enabled_hit)
  );

  always_comb begin
    next_w   = base_w;
    trap_nxt = 1'b0;
    if (any_raised) begin
      next_w[CEXC_LSB +: NFLAGS] = cexc_new;
      if (enabled_hit) begin
        next_w[FTT_LSB +: FTT_W] = FTT_IEEE;
        trap_nxt = 1'b1;
      end else begin
        next_w[AEXC_LSB +: NFLAGS] = base_w[AEXC_LSB +: NFLAGS] | cexc_new;
      end
    end
    if (sw_we) begin
      next_w   = sw_wdata;
      trap_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      fsr_q    <= next_w;
      trap_req <= trap_nxt;
    end
  end

  // R8
  sw_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sw_we) |-> (fsr_q == $past(sw_wdata)) && !trap_req);

  // R4
  trap_keeps_accrued_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (fsr_q[AEXC_LSB +: NFLAGS] == $past(fsr_q[AEXC_LSB +: NFLAGS]))
                 && (fsr_q[FTT_LSB +: FTT_W] == FTT_IEEE));

  // R6
  accrued_no_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_we) |-> ((fsr_q[AEXC_LSB +: NFLAGS] & $past(fsr_q[AEXC_LSB +: NFLAGS]))
                       == $past(fsr_q[AEXC_LSB +: NFLAGS])));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_start) && !$past(flag_vld) && !$past(sw_we)) |->
      (fsr_q[CEXC_LSB +: NFLAGS] == '0) && (fsr_q[FTT_LSB +: FTT_W] == '0));

  // R5
  trap_needs_flags_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(flag_vld) && ($past(flag_in) != '0));
endmodule

// File: tb/test_fpx_status_unit.sv
module test_fpx_status_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_start, flag_vld, sw_we;
  logic [4:0]  flag_in;
  logic [31:0] sw_wdata;
  logic [31:0] fsr_q;
  logic        trap_req;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_status_unit i_fpx_status_unit (
    .clk(clk), .rst(rst), .op_start(op_start), .flag_vld(flag_vld),
    .flag_in(flag_in), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .fsr_q(fsr_q), .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive for one cycle at a falling edge; outputs sampled at the next falling edge
  task automatic cyc(input logic st, input logic fv, input logic [4:0] fl,
                     input logic we, input logic [31:0] wd);
    op_start = st; flag_vld = fv; flag_in = fl; sw_we = we; sw_wdata = wd;
    @(negedge clk);
    op_start = 0; flag_vld = 0; flag_in = 0; sw_we = 0; sw_wdata = 0;
  endtask

  function automatic logic [31:0] make_word(input logic [4:0] tem, input logic [4:0] aexc,
                                            input logic [4:0] cexc);
    return {4'hA, tem, 6'h2A, 3'b101, 4'h5, aexc, cexc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] w, e;
    rst = 1; op_start = 0; flag_vld = 0; flag_in = 0; sw_we = 0; sw_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", fsr_q, 32'h0);
    chk("R1 reset trap", {31'b0, trap_req}, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", fsr_q, 32'h0);

    // exhaustive sweep: enable mask x flag set, start and flags in one cycle
    for (int t = 0; t < 32; t++) begin
      for (int f = 0; f < 32; f++) begin
        logic [4:0] tem, fl, ax;
        tem = 5'(t); fl = 5'(f); ax = 5'(t) ^ 5'h12;
        w = make_word(tem, ax, 5'h1F);
        cyc(0, 0, 0, 1, w);
        chk("R8 load", fsr_q, w);
        cyc(1, 1, fl, 0, 0);
        e = w; e[16:14] = 0; e[4:0] = 0;
        if (fl != 0) begin
          e[4:0] = fl;
          if ((fl & tem) != 0) e[16:14] = 3'd1;
          else e[9:5] = ax | fl;
        end
        if (fl == 0) chk("R7 zero flags", fsr_q, e);
        else if ((fl & tem) != 0) chk("R4 trap word", fsr_q, e);
        else chk("R6 merge word", fsr_q, e);
        chk("R5 trap level", {31'b0, trap_req}, {31'b0, (fl & tem) != 0});
        chk("R9 other bits", fsr_q & 32'hF07E3C00, w & 32'hF07E3C00);
      end
    end

    // start alone, then flags in a later cycle
    w = make_word(5'b01000, 5'b00000, 5'b11111);
    cyc(0, 0, 0, 1, w);
    cyc(1, 0, 0, 0, 0);
    e = w; e[16:14] = 0; e[4:0] = 0;
    chk("R2 clear alone", fsr_q, e);
    cyc(0, 1, 5'b00011, 0, 0);
    e[4:0] = 5'b00011; e[9:5] = 5'b00011;
    chk("R6 separate merge", fsr_q, e);
    cyc(0, 1, 5'b01000, 0, 0);
    e[4:0] = 5'b01011; e[16:14] = 3'd1;
    chk("R4 trap without start", fsr_q, e);
    chk("R5 pulse high", {31'b0, trap_req}, 32'h1);
    cyc(0, 0, 0, 0, 0);
    chk("R5 pulse dropped", {31'b0, trap_req}, 32'h0);
    chk("R9 idle holds", fsr_q, e);

    // flags OR into an uncleared current field
    w = make_word(5'b00000, 5'b00000, 5'b00001);
    cyc(0, 0, 0, 1, w);
    cyc(0, 1, 5'b10000, 0, 0);
    e = w; e[4:0] = 5'b10001; e[9:5] = 5'b10001;
    chk("R3 or into stale", fsr_q, e);

    // each flag lands at its own bit
    for (int b = 0; b < 5; b++) begin
      w = make_word(5'b00000, 5'b00000, 5'b00000);
      cyc(0, 0, 0, 1, w);
      cyc(1, 1, 5'(1 << b), 0, 0);
      chk("R3 flag position", {27'b0, fsr_q[4:0]}, 32'(1 << b));
    end

    // software write collides with a trapping update
    w = make_word(5'b11111, 5'b00000, 5'b00000);
    cyc(0, 0, 0, 1, w);
    cyc(1, 1, 5'b11111, 1, 32'h1234_5678);
    chk("R8 write wins", fsr_q, 32'h1234_5678);
    chk("R8 no trap", {31'b0, trap_req}, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule